// File: doc/BRIEF.md
# Card Host Interrupt Status and Enable Block

This block collects single-cycle event pulses from the command path, the data path, the DMA engine and the card-detect logic of a host-side storage card controller. It records each event in a 32-bit status register and lets software clear recorded events one by one. It derives an error summary bit from the error half of the register and drives a single interrupt line toward the system. Two mask registers control it. The status-enable mask decides which events are recorded at all. The signal-enable mask decides which recorded bits may raise the interrupt line.

Software reaches the three registers through a simple register port: a write strobe, an 8-bit offset and a 32-bit write word, with read data returned combinationally for the offset presented. The status register sits at offset 0x30, the status-enable mask at 0x34 and the signal-enable mask at 0x38. The lower half of the status register holds normal events. The upper half holds errors. Bit 15 holds no event of its own: it is computed from the errors. The card interrupt at bit 8 is a level from the card and is not a pulse.

Top module: `irq_status_regs`

## Requirements
- R1: Offsets 0x30 (status), 0x34 (status-enable) and 0x38 (signal-enable) are selected by `reg_addr`; the two enable registers read back every written bit; any other offset reads as zero, and a write to it changes no register.
- R2: A synchronous active-low reset clears the status register and both mask registers and drives `irq_out` low.
- R3: An event pulse on one of the bits 0, 1, 3, 4, 5, 6, 7 or 16 to 25 of `evt_in`, with the matching status-enable bit set, makes that status bit read 1 from the next clock on. The bit stays at 1 after the pulse ends.
- R4: An event pulse whose status-enable bit is 0 leaves the status bit at 0.
- R5: A write to offset 0x30 clears each pulse-type status bit written as 1 and leaves bits written as 0 unchanged. A write of all ones clears every pulse-type bit.
- R6: Status bit 15 reads as the OR of status bits 31 to 16. Writing bit 15, and pulsing `evt_in[15]`, have no effect on it.
- R7: `irq_out` is high exactly when some bit of the visible status (bit 15 included) is 1 and the same bit of the signal-enable register is 1.
- R8: When an enabled event pulse and a clearing write hit the same status bit in the same cycle, the bit is 1 afterwards.
- R9: Status bit 8 follows the level `evt_in[8]` gated by status-enable bit 8, one clock later. Writing 1 to it does not clear it.
- R10: Status bits 2, 9 to 14 and 26 to 31 always read 0, whatever arrives on `evt_in`.
- R11: Clearing a status-enable bit does not remove a status bit that is already recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 32 | Event pulses by status bit position; bit 8 is a level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the offset on `reg_addr` |
| irq_out | output | 1 | Interrupt line |

## Verification
Recording and signalling are driven from a table of vectors. Each vector combines an event pattern, a status-enable mask, a signal-enable mask and an optional clearing word. Single normal events separate correct recording from stuck bits. Mixed normal and error events, with only bit 15 signal-enabled, show whether the summary bit reaches the interrupt line. Partial enables, partial clears and an all-ones event word separate masking, write-one-to-clear and reserved bits from one another. Directed tests then cover the event-wins-over-clear collision, the level-following card interrupt, a mask turned off after an event, unmapped offsets and a reset in mid-run.

// File: rtl/irq_pkg.sv
// Shared constants and types for the interrupt status block.
// Assumes a 32-bit register word and an 8-bit register offset.
package irq_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_STAT_EN = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_SIG_EN  = 8'h38;

    // Bit roles
    localparam int SUMMARY_BIT = 15;
    localparam int ERR_LO      = 16;

    // Bits recorded from single-cycle pulses
    localparam logic [REG_W-1:0] PULSE_MASK = 32'h03FF_00FB;
    // Bit that follows a level from the card
    localparam logic [REG_W-1:0] LEVEL_MASK = 32'h0000_0100;
    // Bits that never hold anything
    localparam logic [REG_W-1:0] RSVD_MASK  =
        ~(PULSE_MASK | LEVEL_MASK | (32'h1 << SUMMARY_BIT));

    // One register-port write request
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } reg_req_t;

endpackage

// File: rtl/irq_mask_reg.sv
// A plain read/write mask register at one fixed offset.
// Assumes writes are full-word; resets to zero.
module irq_mask_reg
    import irq_pkg::*;
#(
    parameter int                WIDTH  = REG_W,
    parameter logic [ADDR_W-1:0] OFFSET = OFF_STAT_EN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_req_t         req,
    output logic [WIDTH-1:0] q
);

    // Load the mask when a write addresses this offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (req.wr && req.addr == OFFSET)
            q <= req.data[WIDTH-1:0];
    end

endmodule

// File: rtl/irq_status_bank.sv
// Stored status bits. Pulse-type bits latch on an enabled event and
// clear on a write of 1, with the event winning a collision. The
// level-type bit follows its gated source. Reserved and summary
// positions hold no storage and read 0 here.
module irq_status_bank
    import irq_pkg::*;
#(
    parameter int               WIDTH = REG_W,
    parameter logic [WIDTH-1:0] P_MASK = PULSE_MASK,
    parameter logic [WIDTH-1:0] L_MASK = LEVEL_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_in,
    input  logic [WIDTH-1:0] stat_en,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] clr_data,
    output logic [WIDTH-1:0] raw_q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (P_MASK[i]) begin : g_pulse
            logic bit_q;
            // Record an enabled event; otherwise honour a clearing write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (evt_in[i] && stat_en[i])
                    bit_q <= 1'b1;
                else if (clr_stb && clr_data[i])
                    bit_q <= 1'b0;
            end
            assign raw_q[i] = bit_q;
        end else if (L_MASK[i]) begin : g_level
            logic bit_q;
            // Track the gated level; writes do not touch it
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else
                    bit_q <= evt_in[i] && stat_en[i];
            end
            assign raw_q[i] = bit_q;
        end else begin : g_none
            assign raw_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_summary_out.sv
// Forms the visible status word (inserting the error summary bit)
// and the interrupt line. Purely combinational.
module irq_summary_out
    import irq_pkg::*;
#(
    parameter int WIDTH = REG_W,
    parameter int SUM_B = SUMMARY_BIT,
    parameter int ERR_B = ERR_LO
) (
    input  logic [WIDTH-1:0] raw_q,
    input  logic [WIDTH-1:0] sig_en,
    output logic [WIDTH-1:0] status_vis,
    output logic             irq
);

    // Replace the summary position with the OR of the error half
    always_comb begin
        status_vis        = raw_q;
        status_vis[SUM_B] = |raw_q[WIDTH-1:ERR_B];
    end

    // Raise the line when any recorded bit is allowed to signal
    always_comb irq = |(status_vis & sig_en);

endmodule

// File: rtl/irq_status_regs.sv
// Top of the interrupt status block: two mask registers, the status
// bank, the summary/interrupt stage and the read multiplexer.
// Assumes a single-cycle write strobe and combinational reads.
module irq_status_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  evt_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_out
);

    reg_req_t         req;
    logic [REG_W-1:0] stat_en_q;
    logic [REG_W-1:0] sig_en_q;
    logic [REG_W-1:0] raw_status;
    logic [REG_W-1:0] status_vis;
    logic             clr_stb;

    // Bundle the write request
    always_comb begin
        req.wr   = reg_wr;
        req.addr = reg_addr;
        req.data = reg_wdata;
    end

    // Clearing write to the status offset
    always_comb clr_stb = reg_wr && (reg_addr == OFF_STATUS);

    irq_mask_reg #(.WIDTH(REG_W), .OFFSET(OFF_STAT_EN)) u_stat_en (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .q     (stat_en_q)
    );

    irq_mask_reg #(.WIDTH(REG_W), .OFFSET(OFF_SIG_EN)) u_sig_en (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .q     (sig_en_q)
    );

    irq_status_bank #(.WIDTH(REG_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (evt_in),
        .stat_en  (stat_en_q),
        .clr_stb  (clr_stb),
        .clr_data (reg_wdata),
        .raw_q    (raw_status)
    );

    irq_summary_out #(.WIDTH(REG_W)) u_out (
        .raw_q      (raw_status),
        .sig_en     (sig_en_q),
        .status_vis (status_vis),
        .irq        (irq_out)
    );

    // Select read data by offset; unmapped offsets read zero
    always_comb begin
        case (reg_addr)
            OFF_STATUS:  reg_rdata = status_vis;
            OFF_STAT_EN: reg_rdata = stat_en_q;
            OFF_SIG_EN:  reg_rdata = sig_en_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_chk.sv
// Checker for irq_status_regs, attached by bind below.
module irq_status_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  evt_in,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [REG_W-1:0]  stat_en_q,
    input logic [REG_W-1:0]  sig_en_q,
    input logic [REG_W-1:0]  status_q,
    input logic [REG_W-1:0]  status_vis,
    input logic              irq_out
);

    // R2: a cycle in reset leaves everything clear
    p_reset_clear_r2: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && stat_en_q == '0 && sig_en_q == '0 && !irq_out));

    // R3 and R8: an enabled pulse is recorded, clearing write or not
    p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_in & stat_en_q & PULSE_MASK) != '0) |=>
        ((status_q & $past(evt_in & stat_en_q & PULSE_MASK))
            == $past(evt_in & stat_en_q & PULSE_MASK)));

    // R4: no pulse bit rises without an enabled event
    p_no_masked_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~$past(evt_in & stat_en_q) & PULSE_MASK) == '0));

    // R5: written ones clear bits that had no competing event
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_STATUS) |=>
        ((status_q & $past(reg_wdata & PULSE_MASK & ~(evt_in & stat_en_q))) == '0));

    // R6: read word carries a summary consistent with its error half
    p_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_STATUS) |->
        (reg_rdata[SUMMARY_BIT] == (reg_rdata[REG_W-1:ERR_LO] != '0)));

    // R7: with no signal enables the line stays low
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en_q == '0) |-> !irq_out);

    // R9: card interrupt follows its gated level one clock later
    p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_vis[8] == $past(evt_in[8] && stat_en_q[8])));

    // R10: reserved positions never read 1
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_vis & RSVD_MASK) == '0));

endmodule

bind irq_status_regs irq_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_in     (evt_in),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .stat_en_q  (stat_en_q),
    .sig_en_q   (sig_en_q),
    .status_q   (raw_status),
    .status_vis (status_vis),
    .irq_out    (irq_out)
);

// File: tb/irq_status_regs_tb.sv
`timescale 1ns/1ps
module irq_status_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_in = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_status_regs u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    localparam logic [7:0] A_ST  = 8'h30;
    localparam logic [7:0] A_SEN = 8'h34;
    localparam logic [7:0] A_GEN = 8'h38;

    typedef struct packed {
        logic [31:0] evt;
        logic [31:0] sten;
        logic [31:0] sig;
        logic [31:0] clr;
        logic [31:0] exp_st;
        logic        exp_irq;
    } vec_t;

    // Hand-computed from R3 to R7 and R10
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0000_0001, 1'b1},
        '{32'h0001_0002, 32'hFFFF_FFFF, 32'h0000_8000, 32'h0, 32'h0001_8002, 1'b1},
        '{32'h0000_00F8, 32'h0000_0030, 32'hFFFF_FFFF, 32'h0, 32'h0000_0030, 1'b1},
        '{32'h03FF_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF, 32'h03FF_8000, 1'b0},
        '{32'h0300_0003, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0300_0001, 32'h0000_0002, 1'b1},
        '{32'hFFFF_FEFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 32'h03FF_80FB, 1'b0},
        '{32'h0000_0010, 32'h0000_0020, 32'hFFFF_FFFF, 32'h0, 32'h0000_0000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        do_read(A_ST, d);  check("R2 status after reset", d, 32'h0);
        do_read(A_SEN, d); check("R2 stat-en after reset", d, 32'h0);
        do_read(A_GEN, d); check("R2 sig-en after reset", d, 32'h0);
        check("R2 irq after reset", {31'b0, irq_out}, 32'h0);

        // Table walk: R3 R4 R5 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            do_write(A_SEN, VECS[v].sten);
            do_write(A_GEN, VECS[v].sig);
            do_write(A_ST, 32'hFFFF_FFFF);
            pulse(VECS[v].evt);
            if (VECS[v].clr != 32'h0) do_write(A_ST, VECS[v].clr);
            do_read(A_ST, d);
            check($sformatf("R3/R4/R5/R6/R10 vector %0d status", v), d, VECS[v].exp_st);
            check($sformatf("R7 vector %0d irq", v), {31'b0, irq_out}, {31'b0, VECS[v].exp_irq});
        end

        // R1: offsets, readback, unmapped offset
        do_write(A_SEN, 32'hA5A5_5A5A);
        do_write(A_GEN, 32'h1234_5678);
        do_read(A_SEN, d); check("R1 stat-en readback", d, 32'hA5A5_5A5A);
        do_read(A_GEN, d); check("R1 sig-en readback", d, 32'h1234_5678);
        do_write(8'h3C, 32'hFFFF_FFFF);
        do_read(8'h3C, d); check("R1 unmapped reads zero", d, 32'h0);
        do_read(A_SEN, d); check("R1 stat-en untouched by unmapped write", d, 32'hA5A5_5A5A);
        do_read(A_GEN, d); check("R1 sig-en untouched by unmapped write", d, 32'h1234_5678);

        // R8: event and clear on the same bit in the same cycle
        do_write(A_SEN, 32'hFFFF_FFFF);
        do_write(A_GEN, 32'h0);
        do_write(A_ST, 32'hFFFF_FFFF);
        @(negedge clk);
        evt_in = 32'h0000_0001; reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h0000_0001;
        @(negedge clk);
        evt_in = '0; reg_wr = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
        do_read(A_ST, d); check("R8 event beats clear", d, 32'h0000_0001);

        // R6: writing only bit 15 leaves the summary set
        pulse(32'h0002_0000);
        do_write(A_ST, 32'h0000_8000);
        do_read(A_ST, d); check("R6 bit 15 write ignored", d, 32'h0002_8001);

        // R9: card interrupt follows level, not cleared by write
        do_write(A_SEN, 32'h0000_0100);
        do_write(A_GEN, 32'h0000_0100);
        do_write(A_ST, 32'hFFFF_FFFF);
        @(negedge clk);
        evt_in = 32'h0000_0100;
        do_read(A_ST, d); check("R9 level recorded", d, 32'h0000_0100);
        check("R9 irq from card level", {31'b0, irq_out}, 32'h1);
        do_write(A_ST, 32'h0000_0100);
        do_read(A_ST, d); check("R9 write does not clear level bit", d, 32'h0000_0100);
        @(negedge clk);
        evt_in = '0;
        do_read(A_ST, d); check("R9 level released", d, 32'h0);
        check("R9 irq drops with level", {31'b0, irq_out}, 32'h0);

        // R11: disabling a mask bit keeps a recorded event
        do_write(A_SEN, 32'h0000_0001);
        pulse(32'h0000_0001);
        do_write(A_SEN, 32'h0000_0000);
        do_read(A_ST, d); check("R11 recorded bit kept", d, 32'h0000_0001);

        // R2: reset in mid-run
        do_write(A_GEN, 32'h0000_0001);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        do_read(A_ST, d);  check("R2 status after mid-run reset", d, 32'h0);
        do_read(A_GEN, d); check("R2 sig-en after mid-run reset", d, 32'h0);
        check("R2 irq after mid-run reset", {31'b0, irq_out}, 32'h0);

        finished = 1'b1;
        finish_run();
    end

endmodule